// File: doc/BRIEF.md
# Segmented Address Translation Unit

This block turns a segment register value and an offset into a physical address. It has two modes. In the legacy real mode, the segment value is scaled by sixteen and added to a 16-bit offset, which gives a 20-bit address. In protected mode, each segment register holds a selector. Loading a selector fetches an 8-byte descriptor from a global or a local table in memory, one byte per acknowledged read. The base, limit and access byte from that descriptor go into a hidden cache beside the register.

Every later translation reads only that cache. A translation checks the offset against the limit, which can be scaled by the granularity bit, and checks that a write targets a writable data segment. It raises a fault when a check fails. One extra cache slot holds the local-table descriptor, and that slot is loaded from the global table. A host loads selectors through a single load port, issues translation requests on a request port, and waits on `busy` while a fetch is in progress.

Top module: `seg_xlate`

## Requirements
- R1: In real mode (`mode_prot`=0), a translation request gives `xl_addr` = ((segment value × 16) + `xl_off[15:0]`) mod 2^20, zero-extended to 32 bits. `xl_valid` is high in the cycle after the request. Bits 31:16 of the offset are ignored. A real-mode load only stores the value and starts no fetch.
- R2: A real-mode translation never faults, whatever the offset or the write flag.
- R3: A selector is split into three fields: index in bits 15:3, table select in bit 2 (0 = global, 1 = local), and requested level in bits 1:0, which is ignored. A protected-mode load reads 8 bytes at ascending addresses, starting at table base + index × 8.
- R4: The descriptor bytes are laid out as follows: bytes 0–1 hold limit[15:0], bytes 2–4 hold base[23:0], byte 5 holds the access byte, byte 6 holds the granularity flag in bit 7 and limit[19:16] in bits 3:0, and byte 7 holds base[31:24].
- R5: `busy` rises in the cycle after an accepted fetching load. It stays high for exactly 8 cycles when every read is acknowledged at once. While `busy` is high, translation requests produce no `xl_valid` and loads are ignored.
- R6: A protected-mode translation returns cached base + offset. It faults when the offset exceeds the byte limit. An offset equal to the limit is allowed.
- R7: With granularity set, the effective limit is limit × 4096 + FFFh.
- R8: A write faults unless access bit 3 (executable) is 0 and access bit 1 (writable) is 1. Reads are not affected by these bits.
- R9: A global selector with index 0 is null. Loading it starts no fetch and raises no fault. Any later translation through that register faults.
- R10: If index × 8 + 7 exceeds the table limit, `ld_fault` pulses in the cycle after the load. No fetch starts, and the register keeps its previous cache contents.
- R11: Load slot NSEG holds the local-table descriptor, taken from the global table. Selectors with the table-select bit set use its base and limit. A local selector loaded while no local table is valid, or a local-table selector that itself has the table-select bit set, raises `ld_fault`.
- R12: After reset, `busy`, `ld_fault`, `rd_req` and `xl_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_prot | input | 1 | 1 = protected mode, 0 = real mode |
| gdt_base | input | 32 | Global table base address |
| gdt_limit | input | 16 | Global table byte limit |
| ld_we | input | 1 | Load a selector into a slot |
| ld_slot | input | $clog2(NSEG+1) | Target slot; NSEG selects the local-table slot |
| ld_sel | input | 16 | Selector or real-mode segment value |
| busy | output | 1 | Descriptor fetch in progress |
| ld_fault | output | 1 | One-cycle pulse: load rejected |
| rd_req | output | 1 | Memory byte read request |
| rd_addr | output | 32 | Memory byte read address |
| rd_ack | input | 1 | Read data valid this cycle |
| rd_data | input | 8 | Read data byte |
| xl_req | input | 1 | Translation request |
| xl_seg | input | $clog2(NSEG) | Segment register to use |
| xl_off | input | 32 | Offset |
| xl_write | input | 1 | Access is a write |
| xl_valid | output | 1 | Translation result valid |
| xl_addr | output | 32 | Physical address (0 on a fault) |
| xl_fault | output | 1 | Protection fault on this translation |

## Verification
The bench drives each input half a cycle before a rising edge and reads the results at the next falling edge. Translation results and `ld_fault` are registered once, so both are read one falling edge after the request or load. When a load starts a fetch, the bench counts the falling edges on which `busy` is high and expects eight. It takes the first read address at the first of those edges, and it issues the next request only after `busy` has fallen. The cache is written on the same edge that clears `busy`, so a translation issued straight after the fetch already sees the new descriptor.

// File: rtl/seg_pkg.sv
package seg_pkg;

  typedef struct packed {
    logic        vld;
    logic [15:0] sel;
    logic [31:0] base;
    logic [19:0] lim;
    logic        gran;
    logic [7:0]  acc;
  } seg_ent_t;

  // real-mode address: value*16 + offset, wrapping at 20 bits
  function automatic logic [31:0] real_phys(input logic [15:0] s, input logic [15:0] o);
    logic [19:0] sum;
    sum = {s, 4'h0} + {4'h0, o};
    return {12'h000, sum};
  endfunction

  function automatic logic [31:0] eff_limit(input seg_ent_t e);
    return e.gran ? {e.lim, 12'hFFF} : {12'h000, e.lim};
  endfunction

  function automatic logic can_write(input logic [7:0] acc);
    return ~acc[3] & acc[1];
  endfunction

  function automatic seg_ent_t unpack_desc(input logic [63:0] d, input logic [15:0] sel);
    seg_ent_t e;
    e.vld  = 1'b1;
    e.sel  = sel;
    e.lim  = {d[51:48], d[15:0]};
    e.base = {d[63:56], d[39:16]};
    e.acc  = d[47:40];
    e.gran = d[55];
    return e;
  endfunction

endpackage

// File: rtl/seg_desc_fetch.sv
module seg_desc_fetch #(
  parameter int NBYTES = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [31:0]           tbase,
  output logic                  busy,
  output logic                  done,
  output logic [NBYTES*8-1:0]   desc,
  output logic                  rd_req,
  output logic [31:0]           rd_addr,
  input  logic                  rd_ack,
  input  logic [7:0]            rd_data
);
  localparam int CW = $clog2(NBYTES);

  logic                active;
  logic [CW-1:0]       cnt;
  logic [31:0]         base_q;
  logic [NBYTES*8-1:0] byte_q;
  logic                last_byte;

  assign busy      = active;
  assign rd_req    = active;
  assign rd_addr   = base_q + 32'(cnt);
  assign last_byte = active & rd_ack & (cnt == CW'(NBYTES - 1));
  assign done      = last_byte;

  always_comb begin
    desc = byte_q;
    desc[(NBYTES-1)*8 +: 8] = rd_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt    <= '0;
      base_q <= '0;
      byte_q <= '0;
    end else if (!active) begin
      if (start) begin
        active <= 1'b1;
        cnt    <= '0;
        base_q <= tbase;
      end
    end else if (rd_ack) begin
      byte_q[cnt*8 +: 8] <= rd_data;
      cnt <= cnt + 1'b1;
      if (last_byte) active <= 1'b0;
    end
  end

  p_addr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && $past(rd_req && rd_ack) && cnt != '0) |-> rd_addr == $past(rd_addr) + 32'd1);

  p_done_ends_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

endmodule

// File: rtl/seg_cache_bank.sv
module seg_cache_bank
  import seg_pkg::*;
#(
  parameter int NSEG = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [$clog2(NSEG+1)-1:0]   wr_slot,
  input  seg_ent_t                    wr_ent,
  input  logic [$clog2(NSEG)-1:0]     rd_slot,
  output seg_ent_t                    rd_ent,
  output seg_ent_t                    ldt_ent
);
  localparam int SLOT_W = $clog2(NSEG + 1);

  seg_ent_t ent_q [NSEG+1];

  for (genvar i = 0; i <= NSEG; i++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ent_q[i] <= '0;
      else if (wr_en && wr_slot == SLOT_W'(i)) ent_q[i] <= wr_ent;
    end
  end

  assign rd_ent  = ent_q[rd_slot];
  assign ldt_ent = ent_q[NSEG];

endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
  import seg_pkg::*;
#(
  parameter int NSEG = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        mode_prot,
  input  logic [31:0]                 gdt_base,
  input  logic [15:0]                 gdt_limit,
  input  logic                        ld_we,
  input  logic [$clog2(NSEG+1)-1:0]   ld_slot,
  input  logic [15:0]                 ld_sel,
  output logic                        busy,
  output logic                        ld_fault,
  output logic                        rd_req,
  output logic [31:0]                 rd_addr,
  input  logic                        rd_ack,
  input  logic [7:0]                  rd_data,
  input  logic                        xl_req,
  input  logic [$clog2(NSEG)-1:0]     xl_seg,
  input  logic [31:0]                 xl_off,
  input  logic                        xl_write,
  output logic                        xl_valid,
  output logic [31:0]                 xl_addr,
  output logic                        xl_fault
);
  localparam int SLOT_W = $clog2(NSEG + 1);

  seg_ent_t rd_ent, ldt_ent, wr_ent;
  logic [SLOT_W-1:0] wr_slot, pend_slot;
  logic [15:0] pend_sel;
  logic        wr_en, fetch_start, fetch_done;
  logic [63:0] desc;

  // load decode, brought out as named wires
  logic [12:0] sel_idx;
  logic        sel_ti, is_ldt_slot, use_ldt, sel_null, sel_bad, ld_go;
  logic [31:0] tbl_base, tbl_lim, desc_end;

  assign sel_idx     = ld_sel[15:3];
  assign sel_ti      = ld_sel[2];
  assign is_ldt_slot = (ld_slot == SLOT_W'(NSEG));
  assign use_ldt     = sel_ti & ~is_ldt_slot;
  assign ld_go       = ld_we & ~busy;
  assign tbl_base    = use_ldt ? ldt_ent.base : gdt_base;
  assign tbl_lim     = use_ldt ? eff_limit(ldt_ent) : {16'h0, gdt_limit};
  assign desc_end    = {16'h0, sel_idx, 3'b111};
  assign sel_null    = ~sel_ti & (sel_idx == '0);
  assign sel_bad     = (sel_ti & is_ldt_slot) | (use_ldt & ~ldt_ent.vld) | (desc_end > tbl_lim);

  always_comb begin
    wr_en       = 1'b0;
    wr_slot     = ld_slot;
    wr_ent      = '0;
    fetch_start = 1'b0;
    if (fetch_done) begin
      wr_en   = 1'b1;
      wr_slot = pend_slot;
      wr_ent  = unpack_desc(desc, pend_sel);
    end else if (ld_go && !mode_prot) begin
      wr_en       = 1'b1;
      wr_ent.vld  = 1'b1;
      wr_ent.sel  = ld_sel;
      wr_ent.base = {12'h0, ld_sel, 4'h0};
      wr_ent.lim  = 20'h0FFFF;
      wr_ent.acc  = 8'h92;
    end else if (ld_go && sel_null) begin
      wr_en      = 1'b1;
      wr_ent.sel = ld_sel;
    end else if (ld_go && !sel_bad) begin
      fetch_start = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_slot <= '0;
      pend_sel  <= '0;
      ld_fault  <= 1'b0;
    end else begin
      ld_fault <= ld_go & mode_prot & ~sel_null & sel_bad;
      if (fetch_start) begin
        pend_slot <= ld_slot;
        pend_sel  <= ld_sel;
      end
    end
  end

  seg_desc_fetch #(.NBYTES(8)) u_fetch (
    .clk(clk), .rst_n(rst_n), .start(fetch_start),
    .tbase(tbl_base + {16'h0, sel_idx, 3'b000}),
    .busy(busy), .done(fetch_done), .desc(desc),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data)
  );

  seg_cache_bank #(.NSEG(NSEG)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_slot(wr_slot), .wr_ent(wr_ent),
    .rd_slot(xl_seg), .rd_ent(rd_ent), .ldt_ent(ldt_ent)
  );

  // translation
  logic        xl_go, nx_fault;
  logic [31:0] nx_addr;
  assign xl_go = xl_req & ~busy;

  always_comb begin
    if (!mode_prot) begin
      nx_fault = 1'b0;
      nx_addr  = real_phys(rd_ent.sel, xl_off[15:0]);
    end else begin
      nx_fault = ~rd_ent.vld | (xl_off > eff_limit(rd_ent)) |
                 (xl_write & ~can_write(rd_ent.acc));
      nx_addr  = nx_fault ? 32'h0 : rd_ent.base + xl_off;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xl_valid <= 1'b0;
      xl_addr  <= '0;
      xl_fault <= 1'b0;
    end else begin
      xl_valid <= xl_go;
      if (xl_go) begin
        xl_addr  <= nx_addr;
        xl_fault <= nx_fault;
      end
    end
  end

  p_stall_while_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !xl_valid);

  p_busy_after_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(ld_we));

  p_no_fetch_on_fault_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ld_fault |-> !busy);

  p_real_no_fault_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (xl_valid && !$past(mode_prot)) |-> !xl_fault);

endmodule

// File: tb/seg_xlate_test.sv
module seg_xlate_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        mode_prot = 1'b0;
  logic [31:0] gdt_base = 32'h0;
  logic [15:0] gdt_limit = 16'h0027;
  logic        ld_we = 1'b0;
  logic [2:0]  ld_slot = 3'd0;
  logic [15:0] ld_sel = 16'h0;
  logic        busy, ld_fault, rd_req, rd_ack;
  logic [31:0] rd_addr;
  logic [7:0]  rd_data;
  logic        xl_req = 1'b0, xl_write = 1'b0;
  logic [1:0]  xl_seg = 2'd0;
  logic [31:0] xl_off = 32'h0;
  logic        xl_valid, xl_fault;
  logic [31:0] xl_addr;

  logic [7:0] mem [256];
  assign rd_ack  = rd_req;
  assign rd_data = mem[rd_addr[7:0]];

  seg_xlate #(.NSEG(4)) uut (
    .clk(clk), .rst_n(rst_n), .mode_prot(mode_prot), .gdt_base(gdt_base), .gdt_limit(gdt_limit),
    .ld_we(ld_we), .ld_slot(ld_slot), .ld_sel(ld_sel), .busy(busy), .ld_fault(ld_fault),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data),
    .xl_req(xl_req), .xl_seg(xl_seg), .xl_off(xl_off), .xl_write(xl_write),
    .xl_valid(xl_valid), .xl_addr(xl_addr), .xl_fault(xl_fault)
  );

  int checks = 0, failures = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic put_desc(input int a, input logic [31:0] base, input logic [19:0] lim,
                          input logic [7:0] acc, input logic g);
    mem[a]   = lim[7:0];
    mem[a+1] = lim[15:8];
    mem[a+2] = base[7:0];
    mem[a+3] = base[15:8];
    mem[a+4] = base[23:16];
    mem[a+5] = acc;
    mem[a+6] = {g, 3'b000, lim[19:16]};
    mem[a+7] = base[31:24];
  endtask

  task automatic do_load(input int slot, input logic [15:0] sel,
                         output int nbusy, output logic flt, output logic [31:0] a0);
    @(negedge clk); ld_we = 1'b1; ld_slot = slot[2:0]; ld_sel = sel;
    @(negedge clk); ld_we = 1'b0; flt = ld_fault; a0 = rd_addr; nbusy = 0;
    while (busy) begin nbusy++; @(negedge clk); end
  endtask

  task automatic xl(input int seg, input logic [31:0] off, input logic wr,
                    output logic v, output logic [31:0] a, output logic f);
    @(negedge clk); xl_req = 1'b1; xl_seg = seg[1:0]; xl_off = off; xl_write = wr;
    @(negedge clk); xl_req = 1'b0; v = xl_valid; a = xl_addr; f = xl_fault;
  endtask

  // protected translation expecting success (R6 by default)
  task automatic xl_ok(input int seg, input logic [31:0] off, input logic wr,
                       input logic [31:0] exp, input string req);
    logic v, f; logic [31:0] a;
    xl(seg, off, wr, v, a, f);
    chk(v && !f && a == exp, req, a, exp);
  endtask

  task automatic xl_flt(input int seg, input logic [31:0] off, input logic wr, input string req);
    logic v, f; logic [31:0] a;
    xl(seg, off, wr, v, a, f);
    chk(v && f, req, {31'h0, f}, 32'h1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int nb; logic flt; logic [31:0] a0;
    logic v, f; logic [31:0] a;
    logic [15:0] segs [4];
    logic [31:0] offs [6];

    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    put_desc(8'h08, 32'h0001_0000, 20'h000FF, 8'h92, 1'b0);  // rw data
    put_desc(8'h10, 32'h1234_5000, 20'h00003, 8'h90, 1'b1);  // ro data, 4K units
    put_desc(8'h18, 32'h0040_0000, 20'h00FFF, 8'h9A, 1'b0);  // code
    put_desc(8'h20, 32'h0000_0080, 20'h0000F, 8'h82, 1'b0);  // local table
    put_desc(8'h88, 32'h0002_0000, 20'h00010, 8'h92, 1'b0);  // local entry 1

    repeat (3) @(negedge clk);
    // R12 reset state
    chk(!busy && !ld_fault && !rd_req && !xl_valid, "R12",
        {28'h0, busy, ld_fault, rd_req, xl_valid}, 32'h0);
    rst_n = 1'b1;

    // R1 / R2 real-mode sweep
    segs[0] = 16'h0000; segs[1] = 16'h2222; segs[2] = 16'hFFFF; segs[3] = 16'hF000;
    offs[0] = 32'h0; offs[1] = 32'h1; offs[2] = 32'h0016; offs[3] = 32'h8000;
    offs[4] = 32'hFFFF; offs[5] = 32'hABCD_0016;
    for (int s = 0; s < 4; s++) begin
      do_load(s, segs[s], nb, flt, a0);
      chk(nb == 0 && !flt, "R1 real load no fetch", nb, 0);
    end
    for (int s = 0; s < 4; s++)
      for (int o = 0; o < 6; o++)
        for (int w = 0; w < 2; w++) begin
          int unsigned e;
          e = ((int'(segs[s]) * 16) + int'(offs[o][15:0])) % 32'h100000;
          xl(s, offs[o], w[0], v, a, f);
          chk(v && a == e, "R1 real address", a, e);
          chk(!f, "R2 real no fault", {31'h0, f}, 32'h0);
        end

    // protected mode
    mode_prot = 1'b1;
    do_load(0, 16'h0008, nb, flt, a0);
    chk(nb == 8 && !flt, "R5 busy eight cycles", nb, 8);
    chk(a0 == 32'h08, "R3 first read address", a0, 32'h08);
    xl_ok(0, 32'h0, 1'b0, 32'h0001_0000, "R6 base");
    xl_ok(0, 32'hFE, 1'b1, 32'h0001_00FE, "R6 write inside");
    xl_ok(0, 32'hFF, 1'b0, 32'h0001_00FF, "R6 at limit");
    xl_flt(0, 32'h100, 1'b0, "R6 past limit");
    xl_flt(0, 32'h8000_0000, 1'b0, "R6 far past limit");

    do_load(1, 16'h0013, nb, flt, a0);   // index 2, level bits set
    chk(nb == 8 && a0 == 32'h10, "R3 index 2 with level bits", a0, 32'h10);
    xl_ok(1, 32'h0, 1'b0, 32'h1234_5000, "R4 base split bytes");
    xl_ok(1, 32'h3FFF, 1'b0, 32'h1234_8FFF, "R7 granular limit");
    xl_flt(1, 32'h4000, 1'b0, "R7 past granular limit");
    xl_flt(1, 32'h0, 1'b1, "R8 write to read-only");

    do_load(2, 16'h0018, nb, flt, a0);
    xl_ok(2, 32'h10, 1'b0, 32'h0040_0010, "R8 code read");
    xl_flt(2, 32'h10, 1'b1, "R8 code write");

    do_load(3, 16'h0000, nb, flt, a0);
    chk(nb == 0 && !flt, "R9 null load no fetch", nb, 0);
    xl_flt(3, 32'h0, 1'b0, "R9 null access");

    do_load(3, 16'h0004, nb, flt, a0);
    chk(flt && nb == 0, "R11 local without table", {31'h0, flt}, 32'h1);
    do_load(4, 16'h0024, nb, flt, a0);
    chk(flt && nb == 0, "R11 local-table selector with local bit", {31'h0, flt}, 32'h1);
    do_load(4, 16'h0020, nb, flt, a0);    // index 4: end 39 == limit
    chk(!flt && nb == 8 && a0 == 32'h20, "R10 last entry inside limit", a0, 32'h20);
    do_load(3, 16'h000C, nb, flt, a0);
    chk(!flt && nb == 8 && a0 == 32'h88, "R11 local fetch address", a0, 32'h88);
    xl_ok(3, 32'h10, 1'b1, 32'h0002_0010, "R11 local translate");
    xl_flt(3, 32'h11, 1'b0, "R11 local limit");
    do_load(3, 16'h0014, nb, flt, a0);
    chk(flt && nb == 0, "R11 local table limit", {31'h0, flt}, 32'h1);
    xl_ok(3, 32'h10, 1'b0, 32'h0002_0010, "R10 kept after fault");

    do_load(0, 16'h0028, nb, flt, a0);   // index 5: end 47 > 39
    chk(flt && nb == 0, "R10 beyond global limit", {31'h0, flt}, 32'h1);
    xl_ok(0, 32'h5, 1'b0, 32'h0001_0005, "R10 previous cache kept");

    // R5 stall: request and load while busy are ignored
    @(negedge clk); ld_we = 1'b1; ld_slot = 3'd0; ld_sel = 16'h0008;
    @(negedge clk); ld_we = 1'b1; ld_slot = 3'd1; ld_sel = 16'h0000;
    xl_req = 1'b1; xl_seg = 2'd0; xl_off = 32'h0; xl_write = 1'b0;
    @(negedge clk); ld_we = 1'b0; xl_req = 1'b0;
    chk(!xl_valid && busy, "R5 request stalled", {31'h0, xl_valid}, 32'h0);
    while (busy) @(negedge clk);
    xl_ok(1, 32'h0, 1'b0, 32'h1234_5000, "R5 load during busy ignored");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule